// File: doc/BRIEF.md
# SQE Heartbeat Test Generator

This block produces the signal-quality-error heartbeat that a 10 Mb/s twisted-pair PHY returns to its MAC on the MII collision line. It watches the transmit enable coming from the MAC. After each falling edge it waits a fixed delay of about 1 µs, then drives a collision pulse that lasts about 1 µs. The MAC takes that pulse as proof that the collision detection path still works.

The block runs from one free-running clock. The delay and the pulse width are counted in clock cycles that are derived from a clock-frequency parameter. A heartbeat is only produced on a 10 Mb/s link. It is suppressed when repeater mode is selected, either by the strap pin or by the configuration bit, and it is suppressed when the management disable bit is set. The heartbeat is ORed with the real collision indication to form the collision output that goes to the MAC.

Top module: `sqe_heartbeat_gen`

## Requirements
- R1: With the heartbeat allowed, the first rising clock edge that samples `tx_en` low after sampling it high starts a delay. `col_out` goes high right after the edge that comes DELAY_CYC edges later, where DELAY_CYC = CLK_MHZ*DELAY_NS/1000 (25 with the defaults).
- R2: Once high, the heartbeat holds `col_out` high for exactly PULSE_CYC = CLK_MHZ*PULSE_NS/1000 clock cycles (25 with the defaults), then releases it.
- R3: No heartbeat is produced while `spd_10m` is 0 (100 Mb/s). `spd_10m` = 1 means 10 Mb/s.
- R4: No heartbeat is produced while the repeater strap `rptr_pin` is 1.
- R5: No heartbeat is produced while the repeater configuration bit `rptr_cfg` is 1.
- R6: No heartbeat is produced while the disable bit `sqe_off` is 1.
- R7: If `tx_en` is sampled high during the delay or the pulse, the pending heartbeat is cancelled. `col_out` stays low, or drops after that edge.
- R8: If the heartbeat stops being allowed (R3 to R6) during the delay or the pulse, the heartbeat is cancelled and `col_out` drops after the next edge.
- R9: `col_out` is the combinational OR of `col_in` and the heartbeat, so `col_in` = 1 gives `col_out` = 1 in the same cycle.
- R10: A synchronous active-low reset `rst_n` cancels any heartbeat. With `col_in` low, `col_out` is low after the first edge in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock of CLK_MHZ MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable from the MAC |
| spd_10m | input | 1 | 1 = link at 10 Mb/s, 0 = 100 Mb/s |
| rptr_pin | input | 1 | Repeater-mode strap, 1 = repeater |
| rptr_cfg | input | 1 | Repeater-mode configuration bit, 1 = repeater |
| sqe_off | input | 1 | 1 = heartbeat disabled |
| col_in | input | 1 | Real collision indication |
| col_out | output | 1 | MII collision output (heartbeat OR real collision) |

## Verification
The bench measures, in whole clock cycles, the delay from the falling edge to the rise of `col_out` and the width of the pulse. An off-by-one counter load shows up as 24 or 26 instead of 25. Each of the four suppressing inputs is held while a frame ends, so a design that ignores one of them, or that decodes speed with the wrong polarity, produces a stray pulse. `tx_en` is raised again during the delay and during the pulse, and the speed is dropped in the middle of a pulse. A design without cancellation would still pulse, or would finish the pulse. Reset is applied in the middle of a pulse, and `col_in` is driven both while idle and during a pulse to catch a registered or missing OR.

// File: rtl/sqe_pkg.sv
// Shared types for the SQE heartbeat generator.
// Assumes: nothing beyond a synthesizable enum encoding.
package sqe_pkg;

    // Sequencer phases of one heartbeat
    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_PULSE = 2'd2
    } hb_state_t;

endpackage

// File: rtl/sqe_fall_detect.sv
// Detects the high-to-low transition of transmit enable.
// Assumes: tx_en is synchronous to clk. The fall pulse is combinational,
// one cycle wide, and valid in the cycle where tx_en is first seen low.
module sqe_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    output logic tx_fall
);

    logic tx_en_q;

    // Remember the value of tx_en from the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
        end else begin
            tx_en_q <= tx_en;
        end
    end

    // A fall is previous-high, current-low
    always_comb begin
        tx_fall = tx_en_q & ~tx_en;
    end

endmodule

// File: rtl/sqe_qualify.sv
// Decides whether a heartbeat is allowed at all.
// Assumes: all inputs are static configuration or slowly changing status,
// synchronous to the clock of the consumer.
module sqe_qualify (
    input  logic spd_10m,
    input  logic rptr_pin,
    input  logic rptr_cfg,
    input  logic sqe_off,
    output logic allow
);

    logic rptr_mode;

    // Repeater mode comes from either the strap or the configuration bit
    always_comb begin
        rptr_mode = rptr_pin | rptr_cfg;
    end

    // Allowed only at 10 Mb/s, outside repeater mode and when not disabled
    always_comb begin
        allow = spd_10m & ~rptr_mode & ~sqe_off;
    end

endmodule

// File: rtl/sqe_hb_timer.sv
// Delay-then-pulse sequencer for one heartbeat.
// Assumes: trig is a single-cycle request. An abort overrides everything,
// and the counter width fits the larger of the two cycle counts.
module sqe_hb_timer
    import sqe_pkg::*;
#(
    parameter int DELAY_CYC = 25,
    parameter int PULSE_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic abort,
    output logic hb
);

    localparam int MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CW-1:0] DELAY_LD = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);

    hb_state_t     state_q;
    hb_state_t     state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          cnt_zero;

    // Terminal count of the current phase
    always_comb begin
        cnt_zero = (cnt_q == '0);
    end

    // Next-state and counter-load decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (abort) begin
            state_d = HB_IDLE;
            cnt_d   = '0;
        end else begin
            case (state_q)
                HB_IDLE: begin
                    if (trig) begin
                        state_d = HB_WAIT;
                        cnt_d   = DELAY_LD;
                    end
                end
                HB_WAIT: begin
                    if (cnt_zero) begin
                        state_d = HB_PULSE;
                        cnt_d   = PULSE_LD;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                HB_PULSE: begin
                    if (cnt_zero) begin
                        state_d = HB_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_d = HB_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HB_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Heartbeat is high for the whole pulse phase
    always_comb begin
        hb = (state_q == HB_PULSE);
    end

endmodule

// File: rtl/sqe_heartbeat_gen.sv
// Top of the SQE heartbeat generator: a falling edge of transmit enable
// starts a delayed collision pulse, ORed with the real collision indication.
// Assumes: one free-running clock of CLK_MHZ MHz, with all inputs synchronous.
module sqe_heartbeat_gen #(
    parameter int CLK_MHZ  = 25,
    parameter int DELAY_NS = 1000,
    parameter int PULSE_NS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic spd_10m,
    input  logic rptr_pin,
    input  logic rptr_cfg,
    input  logic sqe_off,
    input  logic col_in,
    output logic col_out
);

    localparam int DELAY_RAW = (CLK_MHZ * DELAY_NS) / 1000;
    localparam int PULSE_RAW = (CLK_MHZ * PULSE_NS) / 1000;
    localparam int DELAY_CYC = (DELAY_RAW < 1) ? 1 : DELAY_RAW;
    localparam int PULSE_CYC = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

    logic tx_fall;
    logic allow;
    logic trig;
    logic abort;
    logic hb;

    sqe_fall_detect u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .tx_fall (tx_fall)
    );

    sqe_qualify u_qual (
        .spd_10m  (spd_10m),
        .rptr_pin (rptr_pin),
        .rptr_cfg (rptr_cfg),
        .sqe_off  (sqe_off),
        .allow    (allow)
    );

    // Start on a qualified fall; cancel on renewed transmit or lost permission
    always_comb begin
        trig  = tx_fall & allow;
        abort = tx_en | ~allow;
    end

    sqe_hb_timer #(
        .DELAY_CYC (DELAY_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig),
        .abort (abort),
        .hb    (hb)
    );

    // Merge the heartbeat with the real collision indication
    always_comb begin
        col_out = hb | col_in;
    end

endmodule

// File: rtl/sqe_heartbeat_chk.sv
// Property checker for sqe_heartbeat_gen, attached with bind.
// Assumes: hb is the internal heartbeat of the top, before the OR.
module sqe_heartbeat_chk #(
    parameter int PULSE_CYC = 25
) (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic spd_10m,
    input logic rptr_pin,
    input logic rptr_cfg,
    input logic sqe_off,
    input logic col_in,
    input logic col_out,
    input logic hb
);

    logic [15:0] run_q;

    // Length of the current heartbeat run, for the width check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (hb) begin
            run_q <= run_q + 16'd1;
        end else begin
            run_q <= '0;
        end
    end

    // R2
    hb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hb |-> (run_q < 16'(PULSE_CYC)));

    // R3
    hb_fast_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!spd_10m) |-> !hb);

    // R4
    hb_rptr_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rptr_pin) |-> !hb);

    // R5
    hb_rptr_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rptr_cfg) |-> !hb);

    // R6
    hb_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sqe_off) |-> !hb);

    // R7
    hb_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_en) |-> !hb);

    // R9
    col_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_in || hb) |-> col_out);

endmodule

bind sqe_heartbeat_gen sqe_heartbeat_chk #(
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .spd_10m  (spd_10m),
    .rptr_pin (rptr_pin),
    .rptr_cfg (rptr_cfg),
    .sqe_off  (sqe_off),
    .col_in   (col_in),
    .col_out  (col_out),
    .hb       (hb)
);

// File: tb/sim_sqe_heartbeat_gen.sv
module sim_sqe_heartbeat_gen;

    localparam time TCLK   = 40ns;
    localparam int  DLY    = 25;
    localparam int  WID    = 25;
    localparam int  WIN    = DLY + WID + 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0;
    logic spd_10m = 1'b1;
    logic rptr_pin = 1'b0;
    logic rptr_cfg = 1'b0;
    logic sqe_off = 1'b0;
    logic col_in = 1'b0;
    logic col_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(TCLK/2) clk = ~clk;

    sqe_heartbeat_gen #(.CLK_MHZ(25), .DELAY_NS(1000), .PULSE_NS(1000)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .spd_10m(spd_10m),
        .rptr_pin(rptr_pin), .rptr_cfg(rptr_cfg), .sqe_off(sqe_off),
        .col_in(col_in), .col_out(col_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Send a short frame and measure where col_out rises and how long it stays high
    task automatic frame_measure(output int first, output int width);
        first = 0;
        width = 0;
        @(negedge clk) tx_en = 1'b1;
        repeat (5) @(negedge clk);
        tx_en = 1'b0;
        for (int k = 1; k <= WIN; k++) begin
            @(posedge clk); #1;
            if (col_out) begin
                if (first == 0) first = k;
                width++;
            end
        end
    endtask

    task automatic settle();
        @(negedge clk) tx_en = 1'b0;
        repeat (WIN) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(col_out == 1'b0, "R10 reset", int'(col_out), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        int f, w;
        frame_measure(f, w);
        check(f == DLY + 1, "R1 delay", f, DLY + 1);
        check(w == WID, "R2 width", w, WID);
        frame_measure(f, w);
        check(f == DLY + 1, "R1 delay repeat", f, DLY + 1);
    endtask

    task automatic t_suppress(input int which);
        int f, w;
        spd_10m = (which != 3);
        rptr_pin = (which == 4);
        rptr_cfg = (which == 5);
        sqe_off = (which == 6);
        frame_measure(f, w);
        case (which)
            3: check(w == 0, "R3 100M", w, 0);
            4: check(w == 0, "R4 rptr pin", w, 0);
            5: check(w == 0, "R5 rptr cfg", w, 0);
            default: check(w == 0, "R6 sqe off", w, 0);
        endcase
        @(negedge clk);
        spd_10m = 1'b1; rptr_pin = 1'b0; rptr_cfg = 1'b0; sqe_off = 1'b0;
    endtask

    task automatic t_cancel_delay();
        int hits = 0;
        @(negedge clk) tx_en = 1'b1;
        repeat (5) @(negedge clk);
        tx_en = 1'b0;
        repeat (10) @(negedge clk);
        tx_en = 1'b1;
        for (int k = 0; k < WIN; k++) begin
            @(posedge clk); #1;
            if (col_out) hits++;
        end
        check(hits == 0, "R7 cancel in delay", hits, 0);
        settle();
    endtask

    task automatic t_cancel_pulse(input bit by_speed);
        @(negedge clk) tx_en = 1'b1;
        repeat (5) @(negedge clk);
        tx_en = 1'b0;
        repeat (DLY + 3) @(posedge clk);
        #1;
        check(col_out == 1'b1, by_speed ? "R8 pulse up" : "R7 pulse up", int'(col_out), 1);
        @(negedge clk);
        if (by_speed) spd_10m = 1'b0; else tx_en = 1'b1;
        @(posedge clk); #1;
        check(col_out == 1'b0, by_speed ? "R8 cancel in pulse" : "R7 cancel in pulse",
              int'(col_out), 0);
        @(negedge clk) spd_10m = 1'b1;
        settle();
    endtask

    task automatic t_reset_mid();
        @(negedge clk) tx_en = 1'b1;
        repeat (5) @(negedge clk);
        tx_en = 1'b0;
        repeat (DLY + 4) @(posedge clk);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        check(col_out == 1'b0, "R10 reset mid pulse", int'(col_out), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (WIN) @(posedge clk);
        #1;
        check(col_out == 1'b0, "R10 stays low", int'(col_out), 0);
    endtask

    task automatic t_merge();
        @(negedge clk) col_in = 1'b1;
        #1;
        check(col_out == 1'b1, "R9 col_in idle", int'(col_out), 1);
        @(negedge clk) col_in = 1'b0;
        #1;
        check(col_out == 1'b0, "R9 col_in low", int'(col_out), 0);
        tx_en = 1'b1;
        repeat (5) @(negedge clk);
        tx_en = 1'b0;
        repeat (DLY + 5) @(negedge clk);
        col_in = 1'b1;
        #1;
        check(col_out == 1'b1, "R9 both high", int'(col_out), 1);
        col_in = 1'b0;
        #1;
        check(col_out == 1'b1, "R9 heartbeat alone", int'(col_out), 1);
        settle();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_suppress(3);
        t_suppress(4);
        t_suppress(5);
        t_suppress(6);
        t_cancel_delay();
        t_cancel_pulse(1'b0);
        t_cancel_pulse(1'b1);
        t_reset_mid();
        t_merge();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(TCLK * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule